// File: doc/BRIEF.md
# Modulo Circular Address Generator

This block forms effective addresses for a circular buffer held in data memory. Each request carries the current value of a pointer register, the index of that register (one of sixteen), a signed modifier, an addressing-mode code and a flag saying whether the access belongs to the read path or the write path. When the request's pointer register is the one configured for circular addressing, the modified address is checked against the buffer window and, if it has left the window in the direction of travel, it is folded back by one buffer length. The block returns the effective address, the value to write back into the pointer register and a strobe saying whether that write-back should happen.

Requests enter through a valid/ready port and results leave through a valid/ready port with one output register between them. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high; `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays on the output pins, unchanged, until it is taken with `out_valid` and `out_ready` both high. Configuration pins are sampled when a request is accepted and should be held steady while requests are in flight.

Top module: `mag_top`

## Requirements
- R1: With a non-negative modifier and circular correction active, a modified address strictly greater than `cfg_hi` is reduced by the buffer length (`cfg_hi - cfg_lo + 1`); a modified address equal to `cfg_hi` is left as it is.
- R2: With a negative modifier (bit 15 set) and circular correction active, a modified address strictly less than `cfg_lo` is increased by the buffer length; a modified address equal to `cfg_lo` is left as it is.
- R3: A step that overshoots a boundary by more than one word is folded back by the same single buffer length, landing inside the window.
- R4: Only the boundary matching the modifier's sign is compared: a positive step that ends below `cfg_lo`, or a negative step that ends above `cfg_hi`, is not corrected.
- R5: Mode code 1 (pre-modify): `out_ea` and `out_wb_data` both carry the corrected modified address and `out_wb_en` is 1.
- R6: Mode code 2 (post-modify): `out_ea` carries the unmodified pointer, `out_wb_data` carries the corrected modified address and `out_wb_en` is 1.
- R7: Mode code 3 (register plus offset): `out_ea` carries the corrected sum while `out_wb_en` is 0 and `out_wb_data` equals the unmodified pointer; mode code 0 (plain indirect) gives `out_ea` equal to the pointer with `out_wb_en` 0.
- R8: Correction applies only when `in_idx` equals `cfg_base_sel`; a `cfg_base_sel` of 15 disables correction for every request, so index 15 results are the raw 16-bit sum.
- R9: `in_wr` = 0 marks a read-path request and is corrected only while `cfg_rd_en` is 1; `in_wr` = 1 marks a write-path request and is corrected only while `cfg_wr_en` is 1.
- R10: While `cfg_bitrev_wr` is 1, write-path requests are never corrected, while read-path requests still are.
- R11: `in_ready` equals NOT `out_valid` OR `out_ready`; while `out_valid` is 1 and `out_ready` is 0, all result pins hold their values; `out_wb_idx` echoes the request's `in_idx`.
- R12: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_sel | input | 4 | Index of the pointer register given circular addressing; 15 turns it off |
| cfg_lo | input | 16 | Lowest byte address inside the buffer |
| cfg_hi | input | 16 | Highest byte address inside the buffer |
| cfg_rd_en | input | 1 | Allow correction on read-path requests |
| cfg_wr_en | input | 1 | Allow correction on write-path requests |
| cfg_bitrev_wr | input | 1 | Bit-reversed addressing owns the write path; suppresses write-path correction |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_idx | input | 4 | Index of the pointer register used by the request |
| in_ptr | input | 16 | Current pointer register value |
| in_mod | input | 16 | Signed modifier or offset (two's complement) |
| in_mode | input | 2 | 0 plain, 1 pre-modify, 2 post-modify, 3 register plus offset |
| in_wr | input | 1 | 0 read path, 1 write path |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_ea | output | 16 | Effective address |
| out_wb_data | output | 16 | Value for the pointer register |
| out_wb_en | output | 1 | Pointer register should be updated |
| out_wb_idx | output | 4 | Pointer register index to update |

## Verification
The awkward situations are overshoots that land far past a boundary and steps whose sign points away from the boundary that the address has crossed, since ordinary unit strides never produce them. The stimulus places the pointer a few words from each edge and applies strides of several words in both directions, then runs a long mixed stream of strides up to sixteen words with every mode and path combination while the consumer stalls at random, so that folding, gating and back-pressure all meet in the same sequence.

// File: rtl/mag_pkg.sv
package mag_pkg;
  typedef enum logic [1:0] {
    MAG_PLAIN = 2'd0,
    MAG_PRE   = 2'd1,
    MAG_POST  = 2'd2,
    MAG_OFFS  = 2'd3
  } mag_mode_e;
endpackage

// File: rtl/mag_gate.sv
module mag_gate #(
  parameter int SELW = 4
) (
  input  logic [SELW-1:0] idx,
  input  logic            is_wr,
  input  logic [SELW-1:0] base_sel,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic            bitrev_wr,
  output logic            apply
);
  localparam logic [SELW-1:0] STACK_SEL = {SELW{1'b1}};

  logic sel_hit;
  logic path_ok;

  always_comb begin
    sel_hit = (idx == base_sel) && (base_sel != STACK_SEL);
    if (is_wr) path_ok = wr_en && !bitrev_wr;
    else       path_ok = rd_en;
    apply = sel_hit && path_ok;
  end
endmodule

// File: rtl/mag_wrap.sv
module mag_wrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] modv,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          apply,
  output logic [AW-1:0] sum,
  output logic [AW-1:0] corr
);
  logic [AW-1:0] span;
  logic          going_up;
  logic          past_hi;
  logic          below_lo;

  always_comb begin
    sum      = ptr + modv;
    span     = hi - lo + {{(AW-1){1'b0}}, 1'b1};
    going_up = !modv[AW-1];
    past_hi  = going_up && (sum > hi);
    below_lo = !going_up && (sum < lo);
    if (apply && past_hi)       corr = sum - span;
    else if (apply && below_lo) corr = sum + span;
    else                        corr = sum;
  end
endmodule

// File: rtl/mag_mode_mux.sv
module mag_mode_mux
  import mag_pkg::*;
#(
  parameter int AW = 16
) (
  input  mag_mode_e     mode,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] corr,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb,
  output logic          wb_en
);
  always_comb begin
    ea    = ptr;
    wb    = ptr;
    wb_en = 1'b0;
    unique case (mode)
      MAG_PLAIN: begin
        ea = ptr;
      end
      MAG_PRE: begin
        ea    = corr;
        wb    = corr;
        wb_en = 1'b1;
      end
      MAG_POST: begin
        ea    = ptr;
        wb    = corr;
        wb_en = 1'b1;
      end
      MAG_OFFS: begin
        ea = corr;
      end
      default: ea = ptr;
    endcase
  end
endmodule

// File: rtl/mag_top.sv
module mag_top
  import mag_pkg::*;
#(
  parameter int AW   = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] cfg_base_sel,
  input  logic [AW-1:0]   cfg_lo,
  input  logic [AW-1:0]   cfg_hi,
  input  logic            cfg_rd_en,
  input  logic            cfg_wr_en,
  input  logic            cfg_bitrev_wr,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [SELW-1:0] in_idx,
  input  logic [AW-1:0]   in_ptr,
  input  logic [AW-1:0]   in_mod,
  input  logic [1:0]      in_mode,
  input  logic            in_wr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_ea,
  output logic [AW-1:0]   out_wb_data,
  output logic            out_wb_en,
  output logic [SELW-1:0] out_wb_idx
);
  logic          apply;
  logic [AW-1:0] sum_raw;
  logic [AW-1:0] corr;
  logic [AW-1:0] ea_n;
  logic [AW-1:0] wb_n;
  logic          wb_en_n;
  logic          take;

  mag_gate #(.SELW(SELW)) gate_i (
    .idx       (in_idx),
    .is_wr     (in_wr),
    .base_sel  (cfg_base_sel),
    .rd_en     (cfg_rd_en),
    .wr_en     (cfg_wr_en),
    .bitrev_wr (cfg_bitrev_wr),
    .apply     (apply)
  );

  mag_wrap #(.AW(AW)) wrap_i (
    .ptr   (in_ptr),
    .modv  (in_mod),
    .lo    (cfg_lo),
    .hi    (cfg_hi),
    .apply (apply),
    .sum   (sum_raw),
    .corr  (corr)
  );

  mag_mode_mux #(.AW(AW)) mux_i (
    .mode  (mag_mode_e'(in_mode)),
    .ptr   (in_ptr),
    .corr  (corr),
    .ea    (ea_n),
    .wb    (wb_n),
    .wb_en (wb_en_n)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_ea      <= '0;
      out_wb_data <= '0;
      out_wb_en   <= 1'b0;
      out_wb_idx  <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_ea      <= ea_n;
        out_wb_data <= wb_n;
        out_wb_en   <= wb_en_n;
        out_wb_idx  <= in_idx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  logic unused_sum;
  assign unused_sum = ^sum_raw;
endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
  parameter int AW   = 16,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [SELW-1:0] in_idx,
  input logic [AW-1:0]   in_ptr,
  input logic [AW-1:0]   in_mod,
  input logic [1:0]      in_mode,
  input logic            out_valid,
  input logic            out_ready,
  input logic [AW-1:0]   out_ea,
  input logic [AW-1:0]   out_wb_data,
  input logic            out_wb_en,
  input logic [SELW-1:0] out_wb_idx,
  input logic [SELW-1:0] cfg_base_sel
);
  localparam logic [SELW-1:0] TOP_IDX = {SELW{1'b1}};

  logic [1:0]      cap_mode;
  logic [AW-1:0]   cap_ptr;
  logic [AW-1:0]   cap_mod;
  logic [SELW-1:0] cap_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_mode <= '0;
      cap_ptr  <= '0;
      cap_mod  <= '0;
      cap_idx  <= '0;
    end else if (in_valid && in_ready) begin
      cap_mode <= in_mode;
      cap_ptr  <= in_ptr;
      cap_mod  <= in_mod;
      cap_idx  <= in_idx;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea) && $stable(out_wb_data) && $stable(out_wb_en) && $stable(out_wb_idx)); // R11

  AST_NO_WB_NONMOD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (cap_mode == 2'd0 || cap_mode == 2'd3) |-> !out_wb_en && out_wb_data == cap_ptr); // R7

  AST_POST_EA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_mode == 2'd2 |-> out_wb_en && out_ea == cap_ptr); // R6

  AST_PRE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_mode == 2'd1 |-> out_wb_en && out_ea == out_wb_data); // R5

  AST_TOP_IDX_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_idx == TOP_IDX && cap_mode == 2'd1 |-> out_ea == AW'(cap_ptr + cap_mod)); // R8

  AST_IDX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_wb_idx == cap_idx); // R11

  logic unused_sel;
  assign unused_sel = ^cfg_base_sel;
endmodule

bind mag_top mag_checker #(.AW(AW), .SELW(SELW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_idx       (in_idx),
  .in_ptr       (in_ptr),
  .in_mod       (in_mod),
  .in_mode      (in_mode),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_ea       (out_ea),
  .out_wb_data  (out_wb_data),
  .out_wb_en    (out_wb_en),
  .out_wb_idx   (out_wb_idx),
  .cfg_base_sel (cfg_base_sel)
);

// File: tb/mag_top_tb_top.sv
`timescale 1ns/1ps
module mag_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_base_sel = 4'd3;
  logic [15:0] cfg_lo = 16'h1000;
  logic [15:0] cfg_hi = 16'h101F;
  logic        cfg_rd_en = 1'b1;
  logic        cfg_wr_en = 1'b1;
  logic        cfg_bitrev_wr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_idx = 4'd0;
  logic [15:0] in_ptr = 16'h0;
  logic [15:0] in_mod = 16'h0;
  logic [1:0]  in_mode = 2'd0;
  logic        in_wr = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_ea;
  logic [15:0] out_wb_data;
  logic        out_wb_en;
  logic [3:0]  out_wb_idx;

  always #5 clk = ~clk;

  mag_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_base_sel(cfg_base_sel), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .cfg_bitrev_wr(cfg_bitrev_wr),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_ptr(in_ptr),
    .in_mod(in_mod), .in_mode(in_mode), .in_wr(in_wr),
    .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea),
    .out_wb_data(out_wb_data), .out_wb_en(out_wb_en), .out_wb_idx(out_wb_idx)
  );

  int n_checks = 0;
  int n_errs   = 0;
  string cur_tag = "R1";
  int ready_ctl = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit last_accept = 0;
  bit finished = 0;

  logic [15:0] q_ea[$];
  logic [15:0] q_wb[$];
  logic        q_en[$];
  logic [3:0]  q_idx[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference: integer arithmetic on the requirement text
  task automatic ref_calc(input logic [15:0] ptr, input logic [3:0] idx,
                          input logic [15:0] md, input logic [1:0] mode, input logic wr,
                          output logic [15:0] ea, output logic [15:0] wb, output logic en);
    int p, m, s, lo, hi, len;
    bit on;
    p  = int'(ptr);
    m  = md[15] ? int'(md) - 65536 : int'(md);
    lo = int'(cfg_lo);
    hi = int'(cfg_hi);
    len = hi - lo + 1;
    s = (p + m) & 16'hFFFF;
    on = (idx == cfg_base_sel) && (cfg_base_sel != 4'd15) &&
         (wr ? (cfg_wr_en && !cfg_bitrev_wr) : cfg_rd_en);
    if (on) begin
      if (m >= 0 && s > hi) s = (s - len) & 16'hFFFF;
      else if (m < 0 && s < lo) s = (s + len) & 16'hFFFF;
    end
    case (mode)
      2'd1: begin ea = 16'(s); wb = 16'(s); en = 1'b1; end
      2'd2: begin ea = ptr;    wb = 16'(s); en = 1'b1; end
      2'd3: begin ea = 16'(s); wb = ptr;    en = 1'b0; end
      default: begin ea = ptr; wb = ptr;    en = 1'b0; end
    endcase
  endtask

  always @(posedge clk) begin : model
    bit mv, mr, acc;
    logic [15:0] e_ea, e_wb;
    logic e_en;
    if (!rst_n) begin
      q_ea.delete(); q_wb.delete(); q_en.delete(); q_idx.delete(); q_tag.delete();
      last_accept = 0;
    end else begin
      mv  = q_ea.size() != 0;
      mr  = !mv || out_ready;
      acc = in_valid && mr;
      if (mv && out_ready) begin
        void'(q_ea.pop_front()); void'(q_wb.pop_front()); void'(q_en.pop_front());
        void'(q_idx.pop_front()); void'(q_tag.pop_front());
      end
      if (acc) begin
        ref_calc(in_ptr, in_idx, in_mod, in_mode, in_wr, e_ea, e_wb, e_en);
        q_ea.push_back(e_ea); q_wb.push_back(e_wb); q_en.push_back(e_en);
        q_idx.push_back(in_idx); q_tag.push_back(cur_tag);
      end
      last_accept = acc;
    end
  end

  // Compare on every clock, at the falling edge
  always @(negedge clk) begin : cmp
    bit mv;
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R12", "out_valid in reset", 16'(out_valid), 16'h0);
    end else if (!finished) begin
      mv = q_ea.size() != 0;
      chk(out_valid == mv, "R11", "out_valid", 16'(out_valid), 16'(mv));
      chk(in_ready == (!mv || out_ready), "R11", "in_ready", 16'(in_ready), 16'(!mv || out_ready));
      if (mv && out_valid) begin
        chk(out_ea == q_ea[0], q_tag[0], "out_ea", out_ea, q_ea[0]);
        chk(out_wb_data == q_wb[0], q_tag[0], "out_wb_data", out_wb_data, q_wb[0]);
        chk(out_wb_en == q_en[0], q_tag[0], "out_wb_en", 16'(out_wb_en), 16'(q_en[0]));
        chk(out_wb_idx == q_idx[0], "R11", "out_wb_idx", 16'(out_wb_idx), 16'(q_idx[0]));
      end
    end
  end

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_ctl)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 1'b0;
    endcase
  end

  task automatic send(input string tag, input logic [15:0] ptr, input logic [3:0] idx,
                      input int md, input logic [1:0] mode, input logic wr);
    cur_tag  = tag;
    in_ptr   = ptr;
    in_idx   = idx;
    in_mod   = 16'(md);
    in_mode  = mode;
    in_wr    = wr;
    in_valid = 1'b1;
    do begin @(posedge clk); #1; end while (!last_accept);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    ready_ctl = 0;
    while (q_ea.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: upward wrap and equality edge
    send("R1", 16'h101E, 4'd3, 2, 2'd1, 1'b0);
    send("R1", 16'h101D, 4'd3, 2, 2'd1, 1'b0);
    // R2: downward wrap and equality edge
    send("R2", 16'h1000, 4'd3, -2, 2'd1, 1'b0);
    send("R2", 16'h1002, 4'd3, -2, 2'd1, 1'b0);
    // R3: large overshoots
    send("R3", 16'h101A, 4'd3, 16, 2'd1, 1'b0);
    send("R3", 16'h1004, 4'd3, -12, 2'd1, 1'b1);
    // R4: opposite boundary not compared
    send("R4", 16'h0F00, 4'd3, 2, 2'd1, 1'b0);
    send("R4", 16'h1100, 4'd3, -2, 2'd1, 1'b0);
    // R5/R6/R7 modes
    send("R5", 16'h101E, 4'd3, 4, 2'd1, 1'b0);
    send("R6", 16'h101E, 4'd3, 4, 2'd2, 1'b0);
    send("R6", 16'h1000, 4'd3, -4, 2'd2, 1'b1);
    send("R7", 16'h101E, 4'd3, 4, 2'd3, 1'b0);
    send("R7", 16'h101E, 4'd3, 4, 2'd0, 1'b0);
    // R8: other index, then select 15
    send("R8", 16'h101E, 4'd5, 4, 2'd1, 1'b0);
    drain();
    cfg_base_sel = 4'd15;
    send("R8", 16'h101E, 4'd15, 4, 2'd1, 1'b0);
    send("R8", 16'h1000, 4'd15, -2, 2'd2, 1'b1);
    drain();
    cfg_base_sel = 4'd3;
    // R9: per-path enables
    cfg_rd_en = 1'b0;
    send("R9", 16'h101E, 4'd3, 4, 2'd1, 1'b0);
    send("R9", 16'h101E, 4'd3, 4, 2'd1, 1'b1);
    drain();
    cfg_rd_en = 1'b1; cfg_wr_en = 1'b0;
    send("R9", 16'h101E, 4'd3, 4, 2'd1, 1'b1);
    send("R9", 16'h101E, 4'd3, 4, 2'd1, 1'b0);
    drain();
    cfg_wr_en = 1'b1;
    // R10: bit-reverse owns write path
    cfg_bitrev_wr = 1'b1;
    send("R10", 16'h101E, 4'd3, 4, 2'd1, 1'b1);
    send("R10", 16'h101E, 4'd3, 4, 2'd1, 1'b0);
    drain();
    cfg_bitrev_wr = 1'b0;
    // R11: hard stall then release
    ready_ctl = 2;
    send("R11", 16'h1010, 4'd3, 2, 2'd2, 1'b0);
    repeat (5) @(negedge clk);
    ready_ctl = 0;
    drain();
    // Mixed stream under random back-pressure
    ready_ctl = 1;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] p;
      int st;
      logic [3:0] ix;
      p  = 16'h1000 + 16'((lfsr[4:0] & 5'h1E));
      st = (int'(lfsr[8:5]) + 1) * 2;
      if (lfsr[9]) st = -st;
      ix = lfsr[10] ? 4'd3 : {lfsr[12:11], 2'b01};
      send(lfsr[14] ? "R3" : "R1", p, ix, st, lfsr[14:13], lfsr[15]);
    end
    drain();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule